// File: doc/BRIEF.md
# Fill, Heat and Drain Tank Sequencer

This controller runs a batch treatment tank through a fixed three-phase cycle. While the tank fills it also heats. Once the tank is full it only heats. When the water reads contaminant-free the tank drains, and when it reads empty the cycle starts again. Three level sensors drive it: `tank_full`, `tank_empty` and `water_clean`. It drives a fill pump, a heater and a drain pump. All sensors are taken to be synchronous to `clk` and already debounced.

The phase is held in two flip-flops, `ph_a` and `ph_b`. Each sensor acts as a set or clear on those bits, and only in the phase where it applies. The encoding (A,B) is 01 for fill-and-heat, 11 for heat-only and 10 for drain. With it the heater is simply bit B, and each pump is a single two-input AND of the bits. The code 00 is never entered.

Top module: `tank_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block sits in fill-and-heat: fill pump 1, heater 1, drain pump 0.
- R2: The outputs form {fill, heater, drain} = 110 in fill-and-heat, 010 in heat-only and 001 in drain. The two pumps are never on together.
- R3: In fill-and-heat, `tank_full` high at a rising edge moves the block to heat-only from that edge.
- R4: In heat-only, `water_clean` high at a rising edge moves the block to drain from that edge.
- R5: In drain, `tank_empty` high at a rising edge moves the block to fill-and-heat from that edge.
- R6: A sensor that does not match the current phase has no effect: the outputs stay unchanged over that edge.
- R7: When several sensors are high together, only the one matching the current phase acts. With all three high, the block advances one phase per clock.
- R8: The phase only advances in the order fill-and-heat, heat-only, drain, fill-and-heat, and the all-off output 000 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tank_full | input | 1 | Level sensor: tank is full |
| tank_empty | input | 1 | Level sensor: tank is empty |
| water_clean | input | 1 | Sensor: contents are contaminant-free |
| fill_pump | output | 1 | Fill pump enable |
| heater | output | 1 | Heater enable |
| drain_pump | output | 1 | Drain pump enable |

## Verification
The hardest case to reach is a sensor combination in which an out-of-phase sensor is high together with the one that matches. This is where a wrong priority order or missing phase gating would show. The vector walk holds two or three sensors high in every phase, both with and without the matching sensor among them. It then holds all three high for consecutive clocks, so the block must advance exactly one phase per edge around the whole cycle.

// File: rtl/tank_seq.sv
module tank_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic tank_full,
  input  logic tank_empty,
  input  logic water_clean,
  output logic fill_pump,
  output logic heater,
  output logic drain_pump
);

  logic ph_a, ph_b;

  wire go_fill  = tank_empty  &  ph_a & ~ph_b;
  wire go_heat  = tank_full   & ~ph_a &  ph_b;
  wire go_drain = water_clean &  ph_a &  ph_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_a <= 1'b0;
      ph_b <= 1'b1;
    end else if (go_fill) begin
      ph_a <= 1'b0;
      ph_b <= 1'b1;
    end else if (go_heat) begin
      ph_a <= 1'b1;
      ph_b <= 1'b1;
    end else if (go_drain) begin
      ph_a <= 1'b1;
      ph_b <= 1'b0;
    end
  end

  assign heater     = ph_b;
  assign fill_pump  = ~ph_a &  ph_b;
  assign drain_pump =  ph_a & ~ph_b;

  // R2
  pumps_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_pump && drain_pump));

  // R8
  never_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_pump || heater || drain_pump));

  // R3
  full_to_heat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_pump && tank_full) |=> (heater && !fill_pump && !drain_pump));

  // R4
  clean_to_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (heater && !fill_pump && water_clean) |=> (drain_pump && !heater));

  // R5
  empty_to_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_pump && tank_empty) |=> (fill_pump && heater));

  // R6
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fill_pump && !tank_full) || (drain_pump && !tank_empty) ||
     (heater && !fill_pump && !water_clean))
    |=> ($stable(fill_pump) && $stable(heater) && $stable(drain_pump)));

  // R8
  forward_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drain_pump |=> (drain_pump || fill_pump));

endmodule

// File: tb/tank_seq_test.sv
module tank_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tank_full = 1'b0, tank_empty = 1'b0, water_clean = 1'b0;
  logic fill_pump, heater, drain_pump;
  int applied = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tank_seq uut (
    .clk(clk), .rst_n(rst_n),
    .tank_full(tank_full), .tank_empty(tank_empty), .water_clean(water_clean),
    .fill_pump(fill_pump), .heater(heater), .drain_pump(drain_pump)
  );

  // [9:6] requirement, [5:3] {full,empty,clean}, [2:0] expected {fill,heater,drain}
  localparam int NV = 17;
  localparam logic [9:0] VEC [NV] = '{
    {4'd2, 3'b000, 3'b110},
    {4'd6, 3'b010, 3'b110},
    {4'd6, 3'b001, 3'b110},
    {4'd7, 3'b011, 3'b110},
    {4'd3, 3'b100, 3'b010},
    {4'd6, 3'b100, 3'b010},
    {4'd6, 3'b010, 3'b010},
    {4'd7, 3'b110, 3'b010},
    {4'd7, 3'b011, 3'b001},
    {4'd7, 3'b101, 3'b001},
    {4'd6, 3'b001, 3'b001},
    {4'd6, 3'b100, 3'b001},
    {4'd7, 3'b111, 3'b110},
    {4'd7, 3'b111, 3'b010},
    {4'd7, 3'b111, 3'b001},
    {4'd5, 3'b010, 3'b110},
    {4'd8, 3'b000, 3'b110}
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input logic [3:0] r, input logic [2:0] exp);
    applied++;
    if ({fill_pump, heater, drain_pump} !== exp) begin
      miscompares++;
      $display("FAIL %s: outputs %b expected %b", rname(r),
               {fill_pump, heater, drain_pump}, exp);
    end
  endtask

  task automatic step(input logic [2:0] s);
    {tank_full, tank_empty, water_clean} = s;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    check(4'd1, 3'b110);              // R1 during reset
    step(3'b100);
    check(4'd1, 3'b110);              // R1 sensors ignored while held in reset
    {tank_full, tank_empty, water_clean} = 3'b000;
    rst_n = 1'b1;
    @(negedge clk);
    check(4'd1, 3'b110);              // R1 after release
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][5:3]);
      check(VEC[i][9:6], VEC[i][2:0]);
    end
    // R4: heat-only to drain through water_clean alone
    step(3'b100);
    check(4'd3, 3'b010);
    step(3'b001);
    check(4'd4, 3'b001);
    // R8: full cycle with single sensors returns to fill-and-heat
    step(3'b010);
    check(4'd8, 3'b110);
    // R1: reset from drain phase returns to fill-and-heat
    step(3'b100);
    step(3'b001);
    check(4'd4, 3'b001);
    #2 rst_n = 1'b0;
    #1 check(4'd1, 3'b110);
    {tank_full, tank_empty, water_clean} = 3'b000;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(4'd1, 3'b110);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      miscompares++;
      $display("FAIL R8: watchdog expired, got %0d expected completion", applied);
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end
endmodule